// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical byte address. It shifts the segment left by four bits and adds the offset. It holds four segment registers (code, data, stack and extra), the instruction pointer and the stack pointer.

Each cycle it accepts at most one request of one of four kinds: instruction fetch, data access, stack push or stack pop. It picks the base segment and offset from the request kind. Data accesses may be plain, a string source or a string destination, and a segment override may replace the default base where that is allowed. The physical address appears one cycle later. In the same edge the block moves the instruction pointer forward by the given instruction length, or steps the stack pointer for a push or a pop. A write port loads any of the six registers.

Top module: `seg_addr_unit`

## Requirements
- R1: `pa_valid` is high in the cycle after a cycle with `req_valid` high, and low after any cycle without a request. `pa` is held while `pa_valid` is low.
- R2: The physical address is (segment × 16 + offset) modulo 2^20. A4FB with offset 4872 gives A9822, 028F with 0030 gives 02920, and FFFF with FFFF gives 0FFEF.
- R3: A fetch (`req_kind` = 0) uses the code segment with the instruction pointer as it was before the request. The override inputs have no effect on it.
- R4: A fetch adds `req_ilen` to the instruction pointer, modulo 2^16, on the same edge that registers the address.
- R5: A push (`req_kind` = 2) lowers the stack pointer by 2 and addresses the stack segment at the lowered value. The pointer wraps modulo 2^16.
- R6: A pop (`req_kind` = 3) addresses the stack segment at the current stack pointer, then raises the pointer by 2.
- R7: A data access (`req_kind` = 1, `req_str` = 0) uses the data segment with `req_ea` as the offset. When `ovr_en` is high, the segment coded on `ovr_seg` is used instead. Segment codes are 0 extra, 1 code, 2 stack, 3 data.
- R8: A string source (`req_str` = 1) uses the data segment, and an override may replace it. A string destination (`req_str` = 2) always uses the extra segment and ignores the override.
- R9: Push and pop ignore the override inputs.
- R10: `wr_en` loads `wr_data` into the register coded by `wr_sel`: codes 0 to 3 are the segment codes, 4 is the instruction pointer, 5 is the stack pointer, and 6 and 7 are ignored. A request in the same cycle uses the old values. A write to the instruction pointer or stack pointer takes priority over that request's own update.
- R11: After reset the code segment is FFFF, the other segments, the instruction pointer and the stack pointer are 0, and `pa_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 fetch, 1 data, 2 push, 3 pop |
| req_str | input | 2 | 0 plain data, 1 string source, 2 string destination |
| req_ea | input | 16 | Effective address for data accesses |
| req_ilen | input | 3 | Instruction length for fetch |
| ovr_en | input | 1 | Segment override active |
| ovr_seg | input | 2 | Override segment code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 16 | Register write value |
| pa_valid | output | 1 | Physical address valid |
| pa | output | 20 | Physical address |
| ip_o | output | 16 | Current instruction pointer |
| sp_o | output | 16 | Current stack pointer |

## Verification
Inputs set before a rising edge produce the registered address on that edge, so the address is due exactly one cycle after its request. The instruction pointer, stack pointer and segment registers change on that same edge. The driver sets inputs on falling edges and queues the address the request should produce. The monitor samples one time unit after each rising edge and pops exactly one queued item for each cycle in which `pa_valid` is high. The pointer outputs are compared at the same point, so a change that arrives a cycle early or late is reported.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int SHIFT   = 4;
    localparam int PA_W    = 20;
    localparam int ILEN_W  = 3;
    localparam int STEP    = 2;
    localparam int NSEG    = 4;
    localparam logic [SEG_W-1:0] CS_RESET = 16'hFFFF;

    typedef enum logic [1:0] {K_FETCH = 2'd0, K_DATA = 2'd1, K_PUSH = 2'd2, K_POP = 2'd3} kind_e;
    typedef enum logic [1:0] {SG_EXT = 2'd0, SG_CODE = 2'd1, SG_STK = 2'd2, SG_DAT = 2'd3} seg_e;
    typedef enum logic [1:0] {ST_NONE = 2'd0, ST_SRC = 2'd1, ST_DST = 2'd2, ST_RSV = 2'd3} str_e;

    localparam logic [2:0] WR_IP = 3'd4;
    localparam logic [2:0] WR_SP = 3'd5;

    typedef struct packed {
        logic [NSEG-1:0][SEG_W-1:0] seg;
        logic [OFF_W-1:0]           ip;
        logic [OFF_W-1:0]           sp;
    } regs_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] pa;
    } out_t;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
    import agu_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_sel,
    input  logic [SEG_W-1:0]           wr_data,
    input  logic                       ip_upd,
    input  logic [OFF_W-1:0]           ip_next,
    input  logic                       sp_upd,
    input  logic [OFF_W-1:0]           sp_next,
    output logic [NSEG-1:0][SEG_W-1:0] seg,
    output logic [OFF_W-1:0]           ip,
    output logic [OFF_W-1:0]           sp
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ip_upd) r_d.ip = ip_next;
        if (sp_upd) r_d.sp = sp_next;
        if (wr_en) begin
            for (int i = 0; i < NSEG; i++) begin
                if (wr_sel == 3'(i)) r_d.seg[i] = wr_data;
            end
            if (wr_sel == WR_IP) r_d.ip = wr_data;
            if (wr_sel == WR_SP) r_d.sp = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.seg[SG_CODE] <= CS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign seg = r_q.seg;
    assign ip  = r_q.ip;
    assign sp  = r_q.sp;

    // R10: segment registers change only through the write port
    p_seg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(r_q.seg));
    // R10: a write to the stack pointer wins over the stack update
    p_sp_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WR_SP) |=> (sp == $past(wr_data)));
endmodule

// File: rtl/agu_seg_pick.sv
module agu_seg_pick
    import agu_pkg::*;
(
    input  logic [1:0]                 kind,
    input  logic [1:0]                 str,
    input  logic [OFF_W-1:0]           ea,
    input  logic                       ovr_en,
    input  logic [1:0]                 ovr_seg,
    input  logic [NSEG-1:0][SEG_W-1:0] seg,
    input  logic [OFF_W-1:0]           ip,
    input  logic [OFF_W-1:0]           sp,
    output logic [SEG_W-1:0]           base,
    output logic [OFF_W-1:0]           off,
    output logic [OFF_W-1:0]           sp_step
);
    logic [1:0] code;

    always_comb begin
        code    = SG_DAT;
        off     = ea;
        sp_step = sp;
        unique case (kind_e'(kind))
            K_FETCH: begin
                code = SG_CODE;
                off  = ip;
            end
            K_PUSH: begin
                code    = SG_STK;
                sp_step = sp - OFF_W'(STEP);
                off     = sp_step;
            end
            K_POP: begin
                code    = SG_STK;
                off     = sp;
                sp_step = sp + OFF_W'(STEP);
            end
            default: begin
                if (str == ST_DST)  code = SG_EXT;
                else if (ovr_en)    code = ovr_seg;
                else                code = SG_DAT;
            end
        endcase
        base = seg[code];
    end

    // R8: a string destination is never taken from the code or stack segment code path
    always_comb begin
        if (kind == K_DATA && str == ST_DST) begin
            a_dst_ext_r8: assert (base == seg[SG_EXT]);
        end
    end
endmodule

// File: rtl/agu_phys_add.sv
module agu_phys_add
    import agu_pkg::*;
(
    input  logic [SEG_W-1:0] base,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);
    localparam int SHW   = SEG_W + SHIFT;
    localparam int SUM_W = ((SHW > OFF_W) ? SHW : OFF_W) + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'({base, {SHIFT{1'b0}}}) + SUM_W'(off);
        pa  = sum[PA_W-1:0];
    end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  req_str,
    input  logic [15:0] req_ea,
    input  logic [2:0]  req_ilen,
    input  logic        ovr_en,
    input  logic [1:0]  ovr_seg,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [15:0] wr_data,
    output logic        pa_valid,
    output logic [19:0] pa,
    output logic [15:0] ip_o,
    output logic [15:0] sp_o
);
    logic [NSEG-1:0][SEG_W-1:0] seg;
    logic [OFF_W-1:0]           ip, sp, off, sp_step;
    logic [SEG_W-1:0]           base;
    logic [PA_W-1:0]            pa_c;
    logic                       ip_upd, sp_upd;
    out_t                       o_d, o_q;

    agu_seg_pick u_pick (
        .kind(req_kind), .str(req_str), .ea(req_ea), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .seg(seg), .ip(ip), .sp(sp), .base(base), .off(off), .sp_step(sp_step)
    );

    agu_phys_add u_add (.base(base), .off(off), .pa(pa_c));

    assign ip_upd = req_valid && (req_kind == K_FETCH);
    assign sp_upd = req_valid && (req_kind == K_PUSH || req_kind == K_POP);

    agu_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ip_upd(ip_upd), .ip_next(ip + OFF_W'(req_ilen)),
        .sp_upd(sp_upd), .sp_next(sp_step),
        .seg(seg), .ip(ip), .sp(sp)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = req_valid;
        if (req_valid) o_d.pa = pa_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pa_valid = o_q.valid;
    assign pa       = o_q.pa;
    assign ip_o     = ip;
    assign sp_o     = sp;

    // R1: one result per request, one cycle later
    p_valid_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pa_valid);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!pa_valid && $stable(pa)));
    // R4: fetch advances the instruction pointer by its length
    p_ip_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_upd && !wr_en) |=> (ip_o == $past(ip_o) + 16'($past(req_ilen))));
    // R5: push address low nibble equals the lowered stack pointer
    p_push_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_PUSH && !wr_en) |=>
        (sp_o == $past(sp_o) - 16'd2 && pa[3:0] == sp_o[3:0]));
    // R6: pop addresses the old pointer, then raises it
    p_pop_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_POP && !wr_en) |=>
        (sp_o == $past(sp_o) + 16'd2 && pa[3:0] == $past(sp_o[3:0])));
endmodule

// File: tb/seg_addr_unit_tb.sv
module seg_addr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0, req_str = '0, ovr_seg = '0;
    logic [15:0] req_ea = '0, wr_data = '0;
    logic [2:0]  req_ilen = '0, wr_sel = '0;
    logic        ovr_en = 1'b0, wr_en = 1'b0;
    logic        pa_valid;
    logic [19:0] pa;
    logic [15:0] ip_o, sp_o;

    int n_run = 0, n_fail = 0;
    logic [19:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] m_seg[4];
    logic [15:0] m_ip, m_sp;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    seg_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_str(req_str),
        .req_ea(req_ea), .req_ilen(req_ilen), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pa_valid(pa_valid), .pa(pa), .ip_o(ip_o), .sp_o(sp_o)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return 20'({s, 4'h0} + {4'h0, o});
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares each produced address with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && pa_valid) begin
                if (exp_q.size() == 0) check("R1 unexpected valid", 32'(pa_valid), 32'd0);
                else begin
                    automatic logic [19:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, 32'(pa), 32'(e));
                end
            end
        end
    end

    // Driver: one cycle with optional request and optional write
    task automatic step(input bit rq, input logic [1:0] k, input logic [1:0] st,
                        input logic [15:0] ea, input logic [2:0] il,
                        input bit oe, input logic [1:0] os,
                        input bit we, input logic [2:0] ws, input logic [15:0] wd,
                        input string tag);
        logic [1:0]  code;
        logic [15:0] off;
        logic [15:0] nsp;
        logic [15:0] nip;
        @(negedge clk);
        req_valid = rq; req_kind = k; req_str = st; req_ea = ea; req_ilen = il;
        ovr_en = oe; ovr_seg = os; wr_en = we; wr_sel = ws; wr_data = wd;
        nip = m_ip; nsp = m_sp;
        if (rq) begin
            case (k)
                2'd0: begin code = 2'd1; off = m_ip; nip = m_ip + 16'(il); end
                2'd2: begin code = 2'd2; nsp = m_sp - 16'd2; off = nsp; end
                2'd3: begin code = 2'd2; off = m_sp; nsp = m_sp + 16'd2; end
                default: begin
                    off = ea;
                    if (st == 2'd2) code = 2'd0;
                    else if (oe)   code = os;
                    else           code = 2'd3;
                end
            endcase
            exp_q.push_back(phys(m_seg[code], off));
            tag_q.push_back(tag);
        end
        m_ip = nip; m_sp = nsp;
        if (we) begin
            if (ws < 3'd4) m_seg[ws[1:0]] = wd;
            else if (ws == 3'd4) m_ip = wd;
            else if (ws == 3'd5) m_sp = wd;
        end
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check({tag, " ip"}, 32'(ip_o), 32'(m_ip));
        check({tag, " sp"}, 32'(sp_o), 32'(m_sp));
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        step(0, 0, 0, 0, 0, 0, 0, 1, s, d, "R10 write");
    endtask

    initial begin
        m_seg[0] = 0; m_seg[1] = 16'hFFFF; m_seg[2] = 0; m_seg[3] = 0;
        m_ip = 0; m_sp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset valid", 32'(pa_valid), 0);
        check("R11 reset ip", 32'(ip_o), 0);
        check("R11 reset sp", 32'(sp_o), 0);
        step(1, 0, 0, 0, 3'd1, 0, 0, 0, 0, 0, "R11 R3 reset CS fetch");
        // R2 worked values through the data segment (R7)
        wr(3'd3, 16'hA4FB);
        step(1, 1, 0, 16'h4872, 0, 0, 0, 0, 0, 0, "R2 R7 A4FB:4872");
        wr(3'd3, 16'h028F);
        step(1, 1, 0, 16'h0030, 0, 0, 0, 0, 0, 0, "R2 R7 028F:0030");
        wr(3'd0, 16'h1000); wr(3'd2, 16'h0A00);
        step(1, 1, 0, 16'h0011, 0, 1, 2'd2, 0, 0, 0, "R7 override to stack seg");
        step(1, 1, 2, 16'h0029, 0, 1, 2'd1, 0, 0, 0, "R8 dst ignores override");
        step(1, 1, 1, 16'h0010, 0, 1, 2'd0, 0, 0, 0, "R8 src override to extra");
        step(1, 1, 1, 16'h0010, 0, 0, 0, 0, 0, 0, "R8 src default data");
        // R3 R4 fetch
        wr(3'd1, 16'h0400); wr(3'd4, 16'h0056);
        step(1, 0, 0, 0, 3'd3, 0, 0, 0, 0, 0, "R3 R4 fetch 0400:0056");
        step(1, 0, 0, 0, 3'd2, 1, 2'd3, 0, 0, 0, "R3 fetch ignores override");
        wr(3'd4, 16'hFFFE);
        step(1, 0, 0, 0, 3'd5, 0, 0, 0, 0, 0, "R4 ip wrap");
        // R5 R6 R9 stack
        wr(3'd5, 16'h0100);
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R5 push");
        step(1, 2, 0, 0, 0, 1, 2'd3, 0, 0, 0, "R9 push ignores override");
        step(1, 3, 0, 0, 0, 1, 2'd0, 0, 0, 0, "R9 R6 pop ignores override");
        step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R6 pop");
        wr(3'd5, 16'h0000);
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R5 sp wrap");
        // R2 address wrap
        wr(3'd3, 16'hFFFF);
        step(1, 1, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, "R2 wrap FFFF:FFFF");
        check("R2 wrap model", 32'(phys(16'hFFFF, 16'hFFFF)), 32'h0FFEF);
        // R10 priorities and ignored codes
        step(1, 2, 0, 0, 0, 0, 0, 1, 3'd5, 16'h0200, "R10 sp write beats push");
        step(1, 0, 0, 0, 3'd4, 0, 0, 1, 3'd4, 16'h1234, "R10 ip write beats fetch");
        step(1, 1, 0, 16'h0002, 0, 0, 0, 1, 3'd3, 16'h2000, "R10 request sees old seg");
        wr(3'd6, 16'hBEEF); wr(3'd7, 16'hBEEF);
        step(1, 1, 0, 16'h0002, 0, 0, 0, 0, 0, 0, "R10 codes 6 7 ignored");
        step(1, 0, 0, 0, 3'd1, 0, 0, 0, 0, 0, "R10 codes 6 7 keep CS");
        // R1 idle cycles
        @(negedge clk); @(negedge clk);
        check("R1 idle no valid", 32'(pa_valid), 0);
        check("R1 queue drained", 32'(exp_q.size()), 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule